// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block sits beside a small CPU core. It keeps one sticky pending flag for each interrupt source and masks each flag with that source's enable. It also gates every source with a single global enable. Among the qualified sources it picks the one with the lowest index and presents a request to the core, together with the program address of that source's handler. Source index `i` occupies vector slot `i+1`, because slot 0 belongs to reset. The slot address is the table base plus the slot number times `VEC_SIZE`. When `vsel_i` is high, the table base moves from address 0 to `BOOT_BASE`.

When the core accepts a request by pulsing `irq_ack_i`, the block clears the served flag and the global enable in the same edge. Software may set the global enable again to allow nesting. A return from interrupt (`reti_i`) turns the global enable back on. It also opens a gap in which no request is raised until the core has retired one more instruction (`instr_done_i`).

The control FSM has three states. `ST_IDLE` waits for a qualified source. It goes to `ST_REQ` and latches the winner when the global enable is on and some flag is enabled. `ST_REQ` drives the request with a stable vector. It goes back to `ST_IDLE` on acceptance, or when the latched source stops being qualified (withdraw). `ST_GAP` holds off all requests. It goes to `ST_IDLE` on the first retired instruction that follows the return. A return seen in any state moves the FSM to `ST_GAP`.

Top module: `irqc_top`

## Requirements
- R1: An event pulse on `evt_i[i]` sets flag `i`. A set flag stays set while masked by its own enable or the global enable. It is cleared only by service or by a software clear.
- R2: A 1 on `flag_clr_i[i]` clears flag `i` at the next edge. If an event and a clear reach the same flag in the same cycle, the flag ends up set.
- R3: `irq_req_o` is high only while the global enable, the latched source's flag and that source's enable are all 1.
- R4: The request names the lowest-indexed source whose flag and enable are both 1. `irq_vec_o` equals base + (index+1)*`VEC_SIZE`.
- R5: With `vsel_i`=1 the base is `BOOT_BASE`. With `vsel_i`=0 the base is 0.
- R6: On acceptance (`irq_req_o` and `irq_ack_i` high at an edge) the served flag and the global enable are cleared at that edge, and the other flags are kept.
- R7: `gie_set_i` sets and `gie_clr_i` clears the global enable. If acceptance and `gie_set_i` coincide, acceptance wins and the enable reads 0.
- R8: A `reti_i` pulse sets the global enable and withdraws any request. No request is raised until an `instr_done_i` pulse arrives in a later cycle than the `reti_i` pulse.
- R9: A request rises on the second edge after a qualified flag appears. While it waits for acceptance, its vector does not change, even if a higher-priority source becomes pending.
- R10: After reset all flags are 0, the global enable is 0 and there is no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NSRC | Event pulses, one per source |
| flag_clr_i | input | NSRC | Write-one-to-clear strobes for the flags |
| src_en_i | input | NSRC | Per-source enables |
| gie_set_i | input | 1 | Software set of the global enable |
| gie_clr_i | input | 1 | Software clear of the global enable |
| vsel_i | input | 1 | Vector table base select (1 = `BOOT_BASE`) |
| reti_i | input | 1 | Core executed a return from interrupt |
| instr_done_i | input | 1 | Core retired one instruction |
| irq_ack_i | input | 1 | Core accepts the current request |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | ADDR_W | Handler address of the requested source |
| flags_o | output | NSRC | Current pending flags |
| gie_o | output | 1 | Current global enable |

## Verification
The hardest situation to reach from the ports is the post-return gap. The stimulus has to take an interrupt, keep another qualified flag pending while the global enable is off, and then issue a return. It then holds the instruction strobe low for several cycles to show that the request stays low even though the enable is already back on. The bench also returns while a request is outstanding, and returns in the same cycle as a retired instruction, so that the gap cannot be closed early. Priority and vector placement are swept exhaustively over every pending pattern, every enable pattern and both base selections for a four-source configuration.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_GAP  = 2'd2
    } irqc_state_e;
endpackage

// File: rtl/irqc_flags.sv
module irqc_flags #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic [NSRC-1:0] clr_i,
    input  logic [NSRC-1:0] hw_clr_i,
    output logic [NSRC-1:0] flag_o
);
    logic [NSRC-1:0] flag_q;

    for (genvar g = 0; g < NSRC; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flag_q[g] <= 1'b0;
            else if (evt_i[g])
                flag_q[g] <= 1'b1;
            else if (clr_i[g] || hw_clr_i[g])
                flag_q[g] <= 1'b0;
        end
    end

    assign flag_o = flag_q;

    // R1
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));

    // R1
    flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flag_q & ~clr_i & ~hw_clr_i)) |=>
        ((flag_q & $past(flag_q & ~clr_i & ~hw_clr_i)) == $past(flag_q & ~clr_i & ~hw_clr_i)));

    // R6
    hw_clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hw_clr_i));
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int NSRC  = 8,
    parameter int IDX_W = 3
) (
    input  logic [NSRC-1:0]  pend_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irqc_gie.sv
module irqc_gie (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    input  logic reti_i,
    input  logic sw_set_i,
    input  logic sw_clr_i,
    output logic gie_o
);
    logic gie_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gie_q <= 1'b0;
        else if (accept_i)
            gie_q <= 1'b0;
        else if (reti_i || sw_set_i)
            gie_q <= 1'b1;
        else if (sw_clr_i)
            gie_q <= 1'b0;
    end

    assign gie_o = gie_q;

    // R6
    accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |=> !gie_q);

    // R8
    reti_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && !accept_i) |=> gie_q);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NSRC      = 8,
    parameter int ADDR_W    = 16,
    parameter int VEC_SIZE  = 2,
    parameter int BOOT_BASE = 16'h1C00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   evt_i,
    input  logic [NSRC-1:0]   flag_clr_i,
    input  logic [NSRC-1:0]   src_en_i,
    input  logic              gie_set_i,
    input  logic              gie_clr_i,
    input  logic              vsel_i,
    input  logic              reti_i,
    input  logic              instr_done_i,
    input  logic              irq_ack_i,
    output logic              irq_req_o,
    output logic [ADDR_W-1:0] irq_vec_o,
    output logic [NSRC-1:0]   flags_o,
    output logic              gie_o
);
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    irqc_state_e      state_q, state_d;
    logic [IDX_W-1:0] win_idx_q, win_idx_d;
    logic [IDX_W-1:0] pick_idx;
    logic             pick_valid;
    logic [NSRC-1:0]  flag;
    logic [NSRC-1:0]  hw_clr;
    logic             gie;
    logic             still_q;
    logic             accept;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] slot;

    irqc_flags #(.NSRC(NSRC)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .clr_i    (flag_clr_i),
        .hw_clr_i (hw_clr),
        .flag_o   (flag)
    );

    irqc_prio #(.NSRC(NSRC), .IDX_W(IDX_W)) u_prio (
        .pend_i  (flag & src_en_i),
        .valid_o (pick_valid),
        .idx_o   (pick_idx)
    );

    irqc_gie u_gie (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .reti_i   (reti_i),
        .sw_set_i (gie_set_i),
        .sw_clr_i (gie_clr_i),
        .gie_o    (gie)
    );

    assign still_q = gie && flag[win_idx_q] && src_en_i[win_idx_q];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            win_idx_q <= '0;
        end else begin
            state_q   <= state_d;
            win_idx_q <= win_idx_d;
        end
    end

    // Next state
    always_comb begin
        state_d   = state_q;
        win_idx_d = win_idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (reti_i)
                    state_d = ST_GAP;
                else if (gie && pick_valid) begin
                    state_d   = ST_REQ;
                    win_idx_d = pick_idx;
                end
            end
            ST_REQ: begin
                if (reti_i)
                    state_d = ST_GAP;
                else if (!still_q || irq_ack_i)
                    state_d = ST_IDLE;
            end
            ST_GAP: begin
                if (!reti_i && instr_done_i)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        irq_req_o = (state_q == ST_REQ) && still_q && !reti_i;
        accept    = irq_req_o && irq_ack_i;
        hw_clr    = accept ? (NSRC'(1) << win_idx_q) : '0;
        base      = vsel_i ? ADDR_W'(BOOT_BASE) : '0;
        slot      = ADDR_W'(win_idx_q) + ADDR_W'(1);
        irq_vec_o = base + slot * ADDR_W'(VEC_SIZE);
    end

    assign flags_o = flag;
    assign gie_o   = gie;

    // R3
    req_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (gie_o && ((flags_o & src_en_i) != '0)));

    // R8
    no_req_after_reti_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reti_i |=> !irq_req_o);

    // R9
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && !irq_ack_i && !reti_i) |=> (!irq_req_o || $stable(win_idx_q)));

    // R6
    served_flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !evt_i[win_idx_q]) |=> !flags_o[$past(win_idx_q)]);
endmodule

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;
    localparam int CLK_P     = 10;
    localparam int NSRC      = 4;
    localparam int ADDR_W    = 16;
    localparam int VEC_SIZE  = 2;
    localparam int BOOT_BASE = 16'h0C00;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   evt = '0, clr = '0, en = '0;
    logic              gset = 1'b0, gclr = 1'b0, vsel = 1'b0;
    logic              reti = 1'b0, idone = 1'b0, ack = 1'b0;
    logic              req;
    logic [ADDR_W-1:0] vec;
    logic [NSRC-1:0]   flags;
    logic              gie;
    int total = 0;
    int bad = 0;

    always #(CLK_P/2) clk = ~clk;

    irqc_top #(.NSRC(NSRC), .ADDR_W(ADDR_W), .VEC_SIZE(VEC_SIZE), .BOOT_BASE(BOOT_BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .flag_clr_i(clr), .src_en_i(en),
        .gie_set_i(gset), .gie_clr_i(gclr), .vsel_i(vsel), .reti_i(reti),
        .instr_done_i(idone), .irq_ack_i(ack), .irq_req_o(req), .irq_vec_o(vec),
        .flags_o(flags), .gie_o(gie)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] exp_vec(input int idx, input logic vs);
        return (vs ? ADDR_W'(BOOT_BASE) : ADDR_W'(0)) + ADDR_W'((idx + 1) * VEC_SIZE);
    endfunction

    initial begin
        #(CLK_P * 150000);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(); step(); step();
        rst_n = 1'b1;
        step();
        check("R10 flags", 32'(flags), 0);
        check("R10 gie", 32'(gie), 0);
        check("R10 req", 32'(req), 0);

        gset = 1'b1; step(); gset = 1'b0;
        for (int vs = 0; vs < 2; vs++) begin
            for (int e = 0; e < 16; e++) begin
                for (int p = 0; p < 16; p++) begin
                    int win;
                    clr = '1; en = NSRC'(e); vsel = vs[0];
                    step(); step();
                    clr = '0; evt = NSRC'(p);
                    step();
                    evt = '0;
                    step();
                    win = -1;
                    for (int i = NSRC - 1; i >= 0; i--) if (p[i] && e[i]) win = i;
                    check("R1 sweep flags", 32'(flags), 32'(p));
                    check("R3 sweep req", 32'(req), 32'(win >= 0));
                    if (win >= 0)
                        check(vs ? "R5 sweep vec" : "R4 sweep vec", 32'(vec), 32'(exp_vec(win, vs[0])));
                end
            end
        end

        clr = '1; en = '1; vsel = 1'b0; step(); step(); clr = '0;
        gclr = 1'b1; step(); gclr = 1'b0;
        evt = 4'b0100; step(); evt = '0; step(); step();
        check("R1 masked by gie req", 32'(req), 0);
        check("R1 sticky flag", 32'(flags), 32'h4);
        en = '0; gset = 1'b1; step(); gset = 1'b0; step(); step();
        check("R3 masked by enable req", 32'(req), 0);
        check("R1 sticky under enable mask", 32'(flags), 32'h4);
        en = '1; step(); step();
        check("R9 request after enable", 32'(req), 1);
        check("R4 vec src2", 32'(vec), 32'(exp_vec(2, 1'b0)));

        evt = 4'b0001; step(); evt = '0; step(); step();
        check("R9 req held", 32'(req), 1);
        check("R9 vec stable", 32'(vec), 32'(exp_vec(2, 1'b0)));

        ack = 1'b1; step(); ack = 1'b0;
        check("R6 served flag cleared", 32'(flags), 32'h1);
        check("R6 gie cleared", 32'(gie), 0);
        check("R6 req dropped", 32'(req), 0);

        gset = 1'b1; step(); gset = 1'b0; step();
        check("R7 nested req", 32'(req), 1);
        check("R4 vec src0", 32'(vec), 32'(exp_vec(0, 1'b0)));
        ack = 1'b1; gset = 1'b1; step(); ack = 1'b0; gset = 1'b0;
        check("R7 accept beats set", 32'(gie), 0);
        check("R6 flags after second accept", 32'(flags), 0);

        evt = 4'b0010; clr = 4'b0010; step(); evt = '0; clr = '0;
        check("R2 set wins", 32'(flags), 32'h2);
        clr = 4'b0010; step(); clr = '0;
        check("R2 clear", 32'(flags), 0);

        vsel = 1'b1;
        evt = 4'b1000; step(); evt = '0; step(); step();
        check("R3 gie off req", 32'(req), 0);
        reti = 1'b1; step(); reti = 1'b0;
        check("R8 reti sets gie", 32'(gie), 1);
        step(); step(); step();
        check("R8 gap holds req", 32'(req), 0);
        idone = 1'b1; step(); idone = 1'b0;
        check("R8 idle after instr", 32'(req), 0);
        step();
        check("R8 req after gap", 32'(req), 1);
        check("R5 boot vec src3", 32'(vec), 32'(exp_vec(3, 1'b1)));

        reti = 1'b1; step(); reti = 1'b0;
        check("R8 reti withdraws", 32'(req), 0);
        reti = 1'b1; idone = 1'b1; step(); reti = 1'b0; idone = 1'b0;
        step(); step();
        check("R8 same-cycle instr ignored", 32'(req), 0);
        idone = 1'b1; step(); idone = 1'b0; step();
        check("R8 req after later instr", 32'(req), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule